// File: doc/BRIEF.md
# In-Order Transaction Comparator

This block is a hardware scoreboard for bus traffic. One input port carries the records a model predicts, and the other carries the records observed on the bus. Predicted records wait in a first-in, first-out queue. Each observed record is compared with the oldest waiting prediction. Two counters keep the number of equal pairs and the number of unequal pairs, and the most recent unequal pair stays readable for debug.

A record holds four fields: a 32-bit address, a direction bit, 32-bit write data and 32-bit read data. Neither input port ever stalls. If an observed record arrives while no prediction is waiting, it is counted as a mismatch and a sticky flag reports the unexpected arrival. If a prediction arrives while the queue is full, that prediction is dropped and a sticky overflow flag is set.

Top module: `txn_order_checker`

## Requirements
- R1: While rstN is low, the queue empties, both counters go to zero, and unexpectedFlag, overflowFlag and dbgValid are all cleared.
- R2: Two records are equal only when address, direction, write data and read data all match. An equal compare adds one to matchCount, and the new value is visible after the clock edge that samples the actual record.
- R3: An unequal compare adds one to mismatchCount and leaves matchCount unchanged. A difference in any single field is enough, including the direction bit alone.
- R4: Expected records are compared in the order they arrived. Each actual record is compared with the oldest expected record still in the queue, and that record then leaves the queue.
- R5: An actual record that arrives while the queue is empty and no expected record arrives in the same cycle adds one to mismatchCount and sets the sticky unexpectedFlag. The actual record is not stored.
- R6: If expected and actual records arrive in the same cycle while the queue is empty, they are compared directly with each other and the queue stays empty.
- R7: If expected and actual records arrive in the same cycle while the queue holds entries, the expected record goes to the tail of the queue and the actual record is compared with the head.
- R8: The queue holds DEPTH entries (16 by default). An expected record offered while the queue is full is dropped, sets the sticky overflowFlag, and is never compared.
- R9: Every mismatch latches the expected and actual records into the debug outputs and sets dbgValid. For an unexpected arrival, the expected half of the debug outputs is all zeros. The debug outputs hold their values until the next mismatch.
- R10: expReady and actReady are high in every cycle, so neither input port ever applies back-pressure.
- R11: When the queue is full, the push is resolved before the pop. An expected record that arrives together with an actual record is therefore dropped and sets overflowFlag, while the actual record is still compared with the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| expValid | input | 1 | Expected record present |
| expReady | output | 1 | Expected port accepts (always 1) |
| expAddr | input | 32 | Expected address |
| expWrite | input | 1 | Expected direction, 1 = write |
| expWdata | input | 32 | Expected write data |
| expRdata | input | 32 | Expected read data |
| actValid | input | 1 | Actual record present |
| actReady | output | 1 | Actual port accepts (always 1) |
| actAddr | input | 32 | Actual address |
| actWrite | input | 1 | Actual direction, 1 = write |
| actWdata | input | 32 | Actual write data |
| actRdata | input | 32 | Actual read data |
| matchCount | output | CNT_W | Number of equal compares |
| mismatchCount | output | CNT_W | Number of unequal compares plus unexpected arrivals |
| unexpectedFlag | output | 1 | Sticky: actual record arrived with nothing expected |
| overflowFlag | output | 1 | Sticky: expected record dropped on a full queue |
| dbgValid | output | 1 | Debug registers hold a mismatch |
| dbgExpAddr | output | 32 | Latched expected address |
| dbgExpWrite | output | 1 | Latched expected direction |
| dbgExpWdata | output | 32 | Latched expected write data |
| dbgExpRdata | output | 32 | Latched expected read data |
| dbgActAddr | output | 32 | Latched actual address |
| dbgActWrite | output | 1 | Latched actual direction |
| dbgActWdata | output | 32 | Latched actual write data |
| dbgActRdata | output | 32 | Latched actual read data |

## Verification
The hardest case to reach from the ports is a full queue that sees a push and a pop in the same cycle. To get there, the stimulus first fills the queue with sixteen distinct expected records. It then presents a seventeenth expected record together with an actual record that equals the head entry. After that, it drains the queue one record at a time and confirms that each of the remaining fifteen entries matches in order. A final lone actual record must come back as unexpected, which proves the seventeenth record was never stored. The same-cycle pair on an empty queue is handled the same way: a lone actual record sent right after the pair must also be reported as unexpected.

// File: rtl/txn_cmp_pkg.sv
package txn_cmp_pkg;
  parameter int ADDR_W = 32;
  parameter int DATA_W = 32;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              isWrite;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rdata;
  } txn_rec_t;

  // strobes from control to datapath
  typedef struct packed {
    logic push;       // write expected record at wrIdx
    logic compare;    // compare actual against head or bypass
    logic bypass;     // compare against incoming expected record
    logic unexpected; // actual with nothing to compare
  } cmp_strobe_t;
endpackage

// File: rtl/txn_cmp_ctrl.sv
module txn_cmp_ctrl
  import txn_cmp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             expValid,
  input  logic             actValid,
  output cmp_strobe_t      strobe,
  output logic [PTR_W-1:0] wrIdx,
  output logic [PTR_W-1:0] rdIdx,
  output logic             overflowFlag,
  output logic             unexpectedFlag
);
  localparam int OCC_W = PTR_W + 1;

  logic [OCC_W-1:0] occ;
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             isEmpty, isFull, doPop;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    isEmpty           = (occ == '0);
    isFull            = (occ == OCC_W'(DEPTH));
    doPop             = actValid && !isEmpty;
    strobe.bypass     = actValid && isEmpty && expValid;
    strobe.compare    = actValid && (!isEmpty || expValid);
    strobe.unexpected = actValid && isEmpty && !expValid;
    strobe.push       = expValid && !isFull && !strobe.bypass;
  end

  assign wrIdx = wrPtr;
  assign rdIdx = rdPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      occ            <= '0;
      wrPtr          <= '0;
      rdPtr          <= '0;
      overflowFlag   <= 1'b0;
      unexpectedFlag <= 1'b0;
    end else begin
      occ <= occ + OCC_W'(strobe.push) - OCC_W'(doPop);
      if (strobe.push) wrPtr <= nextPtr(wrPtr);
      if (doPop)       rdPtr <= nextPtr(rdPtr);
      if (expValid && isFull) overflowFlag <= 1'b1;
      if (strobe.unexpected)  unexpectedFlag <= 1'b1;
    end
  end

  // R8
  overflow_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (expValid && isFull) |=> overflowFlag);

  // R8
  occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    occ <= OCC_W'(DEPTH));

  // R5
  unexpected_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (actValid && isEmpty && !expValid) |=> unexpectedFlag);

  // R6
  bypass_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (actValid && expValid && isEmpty) |=> (occ == '0));

  // R11
  full_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (actValid && expValid && isFull) |=> (occ == OCC_W'(DEPTH - 1)));
endmodule

// File: rtl/txn_cmp_dpath.sv
module txn_cmp_dpath
  import txn_cmp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  cmp_strobe_t      strobe,
  input  logic [PTR_W-1:0] wrIdx,
  input  logic [PTR_W-1:0] rdIdx,
  input  txn_rec_t         expRec,
  input  txn_rec_t         actRec,
  output logic [CNT_W-1:0] matchCount,
  output logic [CNT_W-1:0] mismatchCount,
  output logic             dbgValid,
  output txn_rec_t         dbgExp,
  output txn_rec_t         dbgAct
);
  txn_rec_t store [DEPTH];
  txn_rec_t headRec;
  logic     recEqual, isMismatch;

  for (genvar g = 0; g < DEPTH; g++) begin : gEntry
    always_ff @(posedge clk) begin
      if (strobe.push && wrIdx == PTR_W'(g)) store[g] <= expRec;
    end
  end

  always_comb begin
    headRec    = strobe.bypass ? expRec : store[rdIdx];
    recEqual   = (headRec == actRec);
    isMismatch = (strobe.compare && !recEqual) || strobe.unexpected;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchCount    <= '0;
      mismatchCount <= '0;
      dbgValid      <= 1'b0;
      dbgExp        <= '0;
      dbgAct        <= '0;
    end else begin
      if (strobe.compare && recEqual) matchCount <= matchCount + CNT_W'(1);
      if (isMismatch) begin
        mismatchCount <= mismatchCount + CNT_W'(1);
        dbgValid      <= 1'b1;
        dbgExp        <= strobe.unexpected ? '0 : headRec;
        dbgAct        <= actRec;
      end
    end
  end

  // R2
  match_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.compare && recEqual) |=> (matchCount == $past(matchCount) + CNT_W'(1)));

  // R3
  mismatch_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.compare && !recEqual) |=>
      (mismatchCount == $past(mismatchCount) + CNT_W'(1)) && $stable(matchCount));

  // R9
  dbg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.compare || strobe.unexpected) |=>
      $stable(dbgAct) && $stable(dbgExp) && $stable(mismatchCount));

  // R9
  dbg_unexp_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.unexpected |=> dbgValid && (dbgExp == '0));
endmodule

// File: rtl/txn_order_checker.sv
module txn_order_checker
  import txn_cmp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              expValid,
  output logic              expReady,
  input  logic [ADDR_W-1:0] expAddr,
  input  logic              expWrite,
  input  logic [DATA_W-1:0] expWdata,
  input  logic [DATA_W-1:0] expRdata,
  input  logic              actValid,
  output logic              actReady,
  input  logic [ADDR_W-1:0] actAddr,
  input  logic              actWrite,
  input  logic [DATA_W-1:0] actWdata,
  input  logic [DATA_W-1:0] actRdata,
  output logic [CNT_W-1:0]  matchCount,
  output logic [CNT_W-1:0]  mismatchCount,
  output logic              unexpectedFlag,
  output logic              overflowFlag,
  output logic              dbgValid,
  output logic [ADDR_W-1:0] dbgExpAddr,
  output logic              dbgExpWrite,
  output logic [DATA_W-1:0] dbgExpWdata,
  output logic [DATA_W-1:0] dbgExpRdata,
  output logic [ADDR_W-1:0] dbgActAddr,
  output logic              dbgActWrite,
  output logic [DATA_W-1:0] dbgActWdata,
  output logic [DATA_W-1:0] dbgActRdata
);
  localparam int PTR_W = $clog2(DEPTH);

  txn_rec_t         expRec, actRec, dbgExp, dbgAct;
  cmp_strobe_t      strobe;
  logic [PTR_W-1:0] wrIdx, rdIdx;

  assign expRec   = '{addr: expAddr, isWrite: expWrite, wdata: expWdata, rdata: expRdata};
  assign actRec   = '{addr: actAddr, isWrite: actWrite, wdata: actWdata, rdata: actRdata};
  assign expReady = 1'b1;
  assign actReady = 1'b1;

  txn_cmp_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .expValid(expValid), .actValid(actValid),
    .strobe(strobe), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .overflowFlag(overflowFlag), .unexpectedFlag(unexpectedFlag)
  );

  txn_cmp_dpath #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .expRec(expRec), .actRec(actRec),
    .matchCount(matchCount), .mismatchCount(mismatchCount),
    .dbgValid(dbgValid), .dbgExp(dbgExp), .dbgAct(dbgAct)
  );

  assign dbgExpAddr  = dbgExp.addr;
  assign dbgExpWrite = dbgExp.isWrite;
  assign dbgExpWdata = dbgExp.wdata;
  assign dbgExpRdata = dbgExp.rdata;
  assign dbgActAddr  = dbgAct.addr;
  assign dbgActWrite = dbgAct.isWrite;
  assign dbgActWdata = dbgAct.wdata;
  assign dbgActRdata = dbgAct.rdata;

  // R10
  always @(posedge clk) begin
    ready_chk: assert (expReady && actReady);
  end
endmodule

// File: tb/sim_txn_order_checker.sv
`timescale 1ns/1ps
module sim_txn_order_checker;
  import txn_cmp_pkg::*;

  localparam int DEPTH = 16;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic expValid = 1'b0, actValid = 1'b0;
  logic expReady, actReady;
  logic [31:0] expAddr = '0, expWdata = '0, expRdata = '0;
  logic [31:0] actAddr = '0, actWdata = '0, actRdata = '0;
  logic expWrite = 1'b0, actWrite = 1'b0;
  logic [CNT_W-1:0] matchCount, mismatchCount;
  logic unexpectedFlag, overflowFlag, dbgValid;
  logic [31:0] dbgExpAddr, dbgExpWdata, dbgExpRdata;
  logic [31:0] dbgActAddr, dbgActWdata, dbgActRdata;
  logic dbgExpWrite, dbgActWrite;

  int nTests = 0;
  int nFail  = 0;

  always #2.5 clk = ~clk;

  txn_order_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN),
    .expValid(expValid), .expReady(expReady), .expAddr(expAddr), .expWrite(expWrite),
    .expWdata(expWdata), .expRdata(expRdata),
    .actValid(actValid), .actReady(actReady), .actAddr(actAddr), .actWrite(actWrite),
    .actWdata(actWdata), .actRdata(actRdata),
    .matchCount(matchCount), .mismatchCount(mismatchCount),
    .unexpectedFlag(unexpectedFlag), .overflowFlag(overflowFlag), .dbgValid(dbgValid),
    .dbgExpAddr(dbgExpAddr), .dbgExpWrite(dbgExpWrite), .dbgExpWdata(dbgExpWdata),
    .dbgExpRdata(dbgExpRdata), .dbgActAddr(dbgActAddr), .dbgActWrite(dbgActWrite),
    .dbgActWdata(dbgActWdata), .dbgActRdata(dbgActRdata)
  );

  function automatic txn_rec_t mk(input int i);
    txn_rec_t r;
    r.addr    = 32'h4000_0000 + 32'(i) * 32'd16;
    r.isWrite = i[0];
    r.wdata   = 32'hA500_0000 | 32'(i);
    r.rdata   = 32'h5A00_0000 ^ (32'(i) << 8);
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chkCounts(input string req, input int m, input int mm);
    chk({req, " matchCount"}, 64'(matchCount), 64'(m));
    chk({req, " mismatchCount"}, 64'(mismatchCount), 64'(mm));
  endtask

  // drive at a falling edge, return at the next falling edge with valids low
  task automatic step(input logic ev, input txn_rec_t er, input logic av, input txn_rec_t ar);
    expValid = ev;
    {expAddr, expWrite, expWdata, expRdata} = er;
    actValid = av;
    {actAddr, actWrite, actWdata, actRdata} = ar;
    @(negedge clk);
    expValid = 1'b0;
    actValid = 1'b0;
  endtask

  task automatic pushE(input txn_rec_t r); step(1'b1, r, 1'b0, '0); endtask
  task automatic sendA(input txn_rec_t r); step(1'b0, '0, 1'b1, r); endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    expValid = 1'b0;
    actValid = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    doReset();
    chkCounts("R1", 0, 0);
    chk("R1 unexpectedFlag", 64'(unexpectedFlag), 0);
    chk("R1 overflowFlag", 64'(overflowFlag), 0);
    chk("R1 dbgValid", 64'(dbgValid), 0);
    chk("R10 readies", 64'({expReady, actReady}), 64'b11);
  endtask

  task automatic t_match();
    doReset();
    pushE(mk(1));
    sendA(mk(1));
    chkCounts("R2", 1, 0);
    chk("R2 dbgValid", 64'(dbgValid), 0);
  endtask

  task automatic t_mismatch();
    txn_rec_t a, b;
    doReset();
    a = mk(2);
    b = a;
    b.rdata = b.rdata ^ 32'h1;
    pushE(a);
    sendA(b);
    chkCounts("R3", 0, 1);
    chk("R9 dbgValid", 64'(dbgValid), 1);
    chk("R9 dbgExpAddr", 64'(dbgExpAddr), 64'(a.addr));
    chk("R9 dbgExpRdata", 64'(dbgExpRdata), 64'(a.rdata));
    chk("R9 dbgActRdata", 64'(dbgActRdata), 64'(b.rdata));
    b = a;
    b.isWrite = ~a.isWrite;
    pushE(a);
    sendA(b);
    chkCounts("R3 direction", 0, 2);
    chk("R9 dbgActWrite", 64'(dbgActWrite), 64'(b.isWrite));
    chk("R9 dbgExpWrite", 64'(dbgExpWrite), 64'(a.isWrite));
    pushE(mk(3));
    sendA(mk(3));
    chk("R9 dbg hold", 64'(dbgActWrite), 64'(b.isWrite));
  endtask

  task automatic t_order();
    doReset();
    for (int i = 10; i < 13; i++) pushE(mk(i));
    for (int i = 10; i < 13; i++) sendA(mk(i));
    chkCounts("R4", 3, 0);
    pushE(mk(20));
    pushE(mk(21));
    sendA(mk(21));
    chkCounts("R4 oldest", 3, 1);
    chk("R4 dbgExpAddr", 64'(dbgExpAddr), 64'(mk(20).addr));
    sendA(mk(21));
    chkCounts("R4 next", 4, 1);
  endtask

  task automatic t_unexpected();
    doReset();
    sendA(mk(5));
    chkCounts("R5", 0, 1);
    chk("R5 unexpectedFlag", 64'(unexpectedFlag), 1);
    chk("R9 dbgExpAddr zero", 64'(dbgExpAddr), 0);
    chk("R9 dbgExpWdata zero", 64'(dbgExpWdata), 0);
    chk("R9 dbgActAddr", 64'(dbgActAddr), 64'(mk(5).addr));
    pushE(mk(6));
    sendA(mk(6));
    chkCounts("R5 not stored", 1, 1);
    chk("R5 sticky", 64'(unexpectedFlag), 1);
  endtask

  task automatic t_bypass();
    doReset();
    step(1'b1, mk(7), 1'b1, mk(7));
    chkCounts("R6", 1, 0);
    chk("R6 no unexpected", 64'(unexpectedFlag), 0);
    sendA(mk(7));
    chk("R6 queue empty", 64'(unexpectedFlag), 1);
    chkCounts("R6 after", 1, 1);
  endtask

  task automatic t_concurrent();
    doReset();
    pushE(mk(8));
    step(1'b1, mk(9), 1'b1, mk(8));
    chkCounts("R7 head", 1, 0);
    sendA(mk(9));
    chkCounts("R7 tail", 2, 0);
    chk("R7 no unexpected", 64'(unexpectedFlag), 0);
    sendA(mk(9));
    chk("R7 drained", 64'(unexpectedFlag), 1);
  endtask

  task automatic t_overflow();
    doReset();
    for (int i = 0; i < DEPTH; i++) pushE(mk(30 + i));
    chk("R8 not yet", 64'(overflowFlag), 0);
    pushE(mk(99));
    chk("R8 overflowFlag", 64'(overflowFlag), 1);
    for (int i = 0; i < DEPTH; i++) sendA(mk(30 + i));
    chkCounts("R8 all matched", DEPTH, 0);
    chk("R8 no unexpected", 64'(unexpectedFlag), 0);
    sendA(mk(99));
    chk("R8 dropped", 64'(unexpectedFlag), 1);
    chk("R8 sticky", 64'(overflowFlag), 1);
    doReset();
    chk("R1 clears overflow", 64'(overflowFlag), 0);
    chk("R1 clears unexpected", 64'(unexpectedFlag), 0);
    chkCounts("R1 after run", 0, 0);
    sendA(mk(30));
    chk("R1 queue cleared", 64'(unexpectedFlag), 1);
  endtask

  task automatic t_fullPop();
    doReset();
    for (int i = 0; i < DEPTH; i++) pushE(mk(60 + i));
    step(1'b1, mk(98), 1'b1, mk(60));
    chkCounts("R11 head", 1, 0);
    chk("R11 overflowFlag", 64'(overflowFlag), 1);
    for (int i = 1; i < DEPTH; i++) sendA(mk(60 + i));
    chkCounts("R11 rest", DEPTH, 0);
    chk("R11 no unexpected", 64'(unexpectedFlag), 0);
    sendA(mk(98));
    chk("R11 dropped", 64'(unexpectedFlag), 1);
  endtask

  initial begin
    t_reset();
    t_match();
    t_mismatch();
    t_order();
    t_unexpected();
    t_bypass();
    t_concurrent();
    t_overflow();
    t_fullPop();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule